// File: doc/BRIEF.md
# Dual-Bus Address Region Router

This block sits between a CPU memory request port and two downstream buses: a simple strobe-and-acknowledge system bus and a 32-bit Wishbone bus. Each accepted request is sorted by its address into one of four classes: system memory, system IO, Wishbone memory or Wishbone IO. It is then sent to the bus that owns that class. When that bus acknowledges, the router gives the CPU a single registered completion pulse, with the read data taken from the bus that did the work.

The system region starts at address 0 and spans `ADDR_W` bits. When `WB_EN` is 1, the CPU address carries one bit above that span. Setting this bit selects a second region laid out the same way and served by Wishbone. Inside each region the top window of `2**IO_W` bytes is the IO window. With the defaults (`ADDR_W`=24, `IO_W`=16) this gives system memory 0x0000000–0x0FEFFFF, system IO 0x0FF0000–0x0FFFFFF, Wishbone memory 0x1000000–0x1FEFFFF and Wishbone IO 0x1FF0000–0x1FFFFFF. With `WB_EN` at 0 the extra bit is absent, every request goes to the system bus, and the Wishbone outputs stay low.

The CPU raises `cpu_req` for one cycle while `cpu_busy` is low, then waits for `cpu_done`. Only one request is in flight at any time. Reset is asserted asynchronously and released through a two-stage synchronizer. `cpu_busy` stays high until that release has finished.

Top module: `dualbus_region_router`

## Requirements
- R1: After reset, `sys_stb`, `wb_cyc`, `wb_stb`, `cpu_done` and `cpu_busy` are all 0, and `cpu_rdata` is 0.
- R2: A request accepted while `cpu_busy` is low, with address bit `ADDR_W` clear and address bits [ADDR_W-1:IO_W] not all ones, produces a system access with `sys_io`=0. The access carries `sys_addr` equal to the low `ADDR_W` address bits, together with the request's `sys_we`, `sys_wdata` and `sys_be`. No Wishbone cycle is started for it.
- R3: A request with address bit `ADDR_W` clear and bits [ADDR_W-1:IO_W] all ones (0x0FF0000–0x0FFFFFF by default) produces a system access with `sys_io`=1.
- R4: A request with address bit `ADDR_W` set produces a Wishbone cycle and no system strobe. In that cycle `wb_adr` is the low `ADDR_W` address bits and `wb_io` is 1 exactly when bits [ADDR_W-1:IO_W] are all ones. `wb_we`, `wb_dat_o` and `wb_sel` carry the request's values.
- R5: `wb_cyc` and `wb_stb` rise together in the cycle after acceptance. They are held, along with unchanged `wb_adr`, `wb_dat_o`, `wb_we` and `wb_sel`, through every cycle where `wb_ack` is low. Both drop in the cycle after the clock edge that samples `wb_ack` high.
- R6: `sys_stb` is high for exactly one cycle per system access, starting the cycle after acceptance. `sys_ack` is honoured in that cycle or in any later cycle.
- R7: Each request yields exactly one single-cycle `cpu_done` pulse, in the cycle after the edge that samples the serving bus's acknowledge. `cpu_rdata` then holds the data that bus returned, and it keeps that value until the next completion.
- R8: A `cpu_req` raised while `cpu_busy` is high is ignored: no further strobe or cycle starts on either bus.
- R9: An acknowledge on either bus while no access is outstanding on that bus produces no `cpu_done` and leaves `cpu_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Request pulse, taken when `cpu_busy` is low |
| cpu_we | input | 1 | Request is a write |
| cpu_addr | input | ADDR_W+WB_EN | Request byte address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_be | input | DATA_W/8 | Byte enables |
| cpu_busy | output | 1 | A request is in flight, or reset is still being released |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Registered read data |
| sys_stb | output | 1 | System bus one-cycle strobe |
| sys_io | output | 1 | System access targets the IO window |
| sys_we | output | 1 | System write |
| sys_addr | output | ADDR_W | System address |
| sys_wdata | output | DATA_W | System write data |
| sys_be | output | DATA_W/8 | System byte enables |
| sys_ack | input | 1 | System acknowledge |
| sys_rdata | input | DATA_W | System read data |
| wb_cyc | output | 1 | Wishbone cycle |
| wb_stb | output | 1 | Wishbone strobe |
| wb_we | output | 1 | Wishbone write enable |
| wb_io | output | 1 | Wishbone access targets the IO window |
| wb_adr | output | ADDR_W | Wishbone address |
| wb_dat_o | output | DATA_W | Wishbone write data |
| wb_sel | output | DATA_W/8 | Wishbone byte selects |
| wb_ack | input | 1 | Wishbone acknowledge |
| wb_dat_i | input | DATA_W | Wishbone read data |

## Verification
Routing is tested with addresses placed on each side of every region edge: 0, the last memory byte and the first IO byte of both regions, the top of the system region, and the first Wishbone byte. Each of these pairs separates a correct compare from an off-by-one or a wrong bit. Random requests are then spread evenly over the four classes, with random direction, data, byte enables and acknowledge latencies of 0 to 3 cycles. These show that fields are passed through unchanged and that read data comes from the bus that served the request, since each bus model returns a different function of the address. Pokes at `cpu_req` while busy and stray acknowledges while idle separate real completions from spurious ones.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

  typedef enum logic [1:0] {
    RGN_SYS_MEM = 2'd0,
    RGN_SYS_IO  = 2'd1,
    RGN_WB_MEM  = 2'd2,
    RGN_WB_IO   = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SYS  = 2'd1,
    ST_WB   = 2'd2
  } route_state_e;

  function automatic logic rgn_is_wb(input region_e r);
    return r[1];
  endfunction

  function automatic logic rgn_is_io(input region_e r);
    return r[0];
  endfunction

endpackage

// File: rtl/dbr_reset_sync.sv
module dbr_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/dbr_region_classify.sv
module dbr_region_classify
  import dbr_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int IO_W   = 16,
  parameter int WB_EN  = 1,
  localparam int HI_W  = ADDR_W + WB_EN - IO_W
) (
  input  logic [HI_W-1:0] addr_hi,
  output region_e         region
);
  localparam int WIN_W = ADDR_W - IO_W;

  logic in_wb;
  logic in_io;

  assign in_io = &addr_hi[WIN_W-1:0];

  generate
    if (WB_EN != 0) begin : g_wb_bit
      assign in_wb = addr_hi[WIN_W];
    end else begin : g_no_wb_bit
      assign in_wb = 1'b0;
    end
  endgenerate

  always_comb begin
    unique case ({in_wb, in_io})
      2'b00:   region = RGN_SYS_MEM;
      2'b01:   region = RGN_SYS_IO;
      2'b10:   region = RGN_WB_MEM;
      default: region = RGN_WB_IO;
    endcase
  end
endmodule

// File: rtl/dbr_sys_port.sv
module dbr_sys_port #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              req_io,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  output logic              sys_stb,
  output logic              sys_io,
  output logic              sys_we,
  output logic [ADDR_W-1:0] sys_addr,
  output logic [DATA_W-1:0] sys_wdata,
  output logic [BE_W-1:0]   sys_be
);
  logic stb_q;
  logic stb_d;

  // strobe lives for the single cycle after launch
  always_comb begin
    stb_d = launch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= stb_d;
  end

  assign sys_stb   = stb_q;
  assign sys_io    = stb_q & req_io;
  assign sys_we    = stb_q & req_we;
  assign sys_addr  = stb_q ? req_addr  : '0;
  assign sys_wdata = stb_q ? req_wdata : '0;
  assign sys_be    = stb_q ? req_be    : '0;
endmodule

// File: rtl/dbr_wb_port.sv
module dbr_wb_port #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              req_io,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  input  logic              wb_ack,
  output logic              ack_taken,
  output logic              wb_cyc,
  output logic              wb_stb,
  output logic              wb_we,
  output logic              wb_io,
  output logic [ADDR_W-1:0] wb_adr,
  output logic [DATA_W-1:0] wb_dat_o,
  output logic [BE_W-1:0]   wb_sel
);
  logic cyc_q;
  logic cyc_d;

  assign ack_taken = cyc_q & wb_ack;

  always_comb begin
    cyc_d = cyc_q;
    if (launch)         cyc_d = 1'b1;
    else if (ack_taken) cyc_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_q <= 1'b0;
    else        cyc_q <= cyc_d;
  end

  assign wb_cyc   = cyc_q;
  assign wb_stb   = cyc_q;
  assign wb_we    = cyc_q & req_we;
  assign wb_io    = cyc_q & req_io;
  assign wb_adr   = cyc_q ? req_addr  : '0;
  assign wb_dat_o = cyc_q ? req_wdata : '0;
  assign wb_sel   = cyc_q ? req_be    : '0;
endmodule

// File: rtl/dualbus_region_router.sv
module dualbus_region_router
  import dbr_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int IO_W   = 16,
  parameter int WB_EN  = 1,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic [ADDR_W+WB_EN-1:0] cpu_addr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  input  logic [DATA_W/8-1:0]     cpu_be,
  output logic                    cpu_busy,
  output logic                    cpu_done,
  output logic [DATA_W-1:0]       cpu_rdata,
  output logic                    sys_stb,
  output logic                    sys_io,
  output logic                    sys_we,
  output logic [ADDR_W-1:0]       sys_addr,
  output logic [DATA_W-1:0]       sys_wdata,
  output logic [DATA_W/8-1:0]     sys_be,
  input  logic                    sys_ack,
  input  logic [DATA_W-1:0]       sys_rdata,
  output logic                    wb_cyc,
  output logic                    wb_stb,
  output logic                    wb_we,
  output logic                    wb_io,
  output logic [ADDR_W-1:0]       wb_adr,
  output logic [DATA_W-1:0]       wb_dat_o,
  output logic [DATA_W/8-1:0]     wb_sel,
  input  logic                    wb_ack,
  input  logic [DATA_W-1:0]       wb_dat_i
);
  localparam int CPU_AW = ADDR_W + WB_EN;
  localparam int BE_W   = DATA_W / 8;

  logic rst_sync_n;

  dbr_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // ---------------- classification ----------------
  region_e req_region;

  dbr_region_classify #(
    .ADDR_W (ADDR_W),
    .IO_W   (IO_W),
    .WB_EN  (WB_EN)
  ) u_cls (
    .addr_hi (cpu_addr[CPU_AW-1:IO_W]),
    .region  (req_region)
  );

  // ---------------- control ----------------
  route_state_e state_q, state_d;
  logic         accept;
  logic         sys_launch, wb_launch;
  logic         sys_fin, wb_fin;
  logic         wb_ack_taken;
  logic         done_d, done_q;
  logic         rdata_en;
  logic [DATA_W-1:0] rdata_d, rdata_q;

  assign cpu_busy   = (state_q != ST_IDLE) | ~rst_sync_n;
  assign accept     = cpu_req & ~cpu_busy;
  assign sys_launch = accept & ~rgn_is_wb(req_region);
  assign wb_launch  = accept &  rgn_is_wb(req_region);
  assign sys_fin    = (state_q == ST_SYS) & sys_ack;
  assign wb_fin     = (state_q == ST_WB)  & wb_ack_taken;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (sys_launch)     state_d = ST_SYS;
        else if (wb_launch) state_d = ST_WB;
      end
      ST_SYS:  if (sys_fin) state_d = ST_IDLE;
      ST_WB:   if (wb_fin)  state_d = ST_IDLE;
      default:              state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_IDLE;
    else             state_q <= state_d;
  end

  // ---------------- request capture ----------------
  logic              req_io_q, req_we_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [DATA_W-1:0] req_wdata_q;
  logic [BE_W-1:0]   req_be_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      req_io_q    <= 1'b0;
      req_we_q    <= 1'b0;
      req_addr_q  <= '0;
      req_wdata_q <= '0;
      req_be_q    <= '0;
    end else if (accept) begin
      req_io_q    <= rgn_is_io(req_region);
      req_we_q    <= cpu_we;
      req_addr_q  <= cpu_addr[ADDR_W-1:0];
      req_wdata_q <= cpu_wdata;
      req_be_q    <= cpu_be;
    end
  end

  // ---------------- system bus side ----------------
  dbr_sys_port #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_sys (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .launch    (sys_launch),
    .req_io    (req_io_q),
    .req_we    (req_we_q),
    .req_addr  (req_addr_q),
    .req_wdata (req_wdata_q),
    .req_be    (req_be_q),
    .sys_stb   (sys_stb),
    .sys_io    (sys_io),
    .sys_we    (sys_we),
    .sys_addr  (sys_addr),
    .sys_wdata (sys_wdata),
    .sys_be    (sys_be)
  );

  // ---------------- Wishbone side ----------------
  generate
    if (WB_EN != 0) begin : g_wb
      dbr_wb_port #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
      ) u_wb (
        .clk       (clk),
        .rst_n     (rst_sync_n),
        .launch    (wb_launch),
        .req_io    (req_io_q),
        .req_we    (req_we_q),
        .req_addr  (req_addr_q),
        .req_wdata (req_wdata_q),
        .req_be    (req_be_q),
        .wb_ack    (wb_ack),
        .ack_taken (wb_ack_taken),
        .wb_cyc    (wb_cyc),
        .wb_stb    (wb_stb),
        .wb_we     (wb_we),
        .wb_io     (wb_io),
        .wb_adr    (wb_adr),
        .wb_dat_o  (wb_dat_o),
        .wb_sel    (wb_sel)
      );
    end else begin : g_no_wb
      logic unused_wb_in;
      assign unused_wb_in = ^{wb_ack, wb_dat_i, wb_launch};
      assign wb_ack_taken = 1'b0;
      assign wb_cyc       = 1'b0;
      assign wb_stb       = 1'b0;
      assign wb_we        = 1'b0;
      assign wb_io        = 1'b0;
      assign wb_adr       = '0;
      assign wb_dat_o     = '0;
      assign wb_sel       = '0;
    end
  endgenerate

  // ---------------- response ----------------
  always_comb begin
    done_d   = sys_fin | wb_fin;
    rdata_en = done_d;
    rdata_d  = wb_fin ? wb_dat_i : sys_rdata;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) done_q <= 1'b0;
    else             done_q <= done_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

  assign cpu_done  = done_q;
  assign cpu_rdata = rdata_q;
endmodule

// File: rtl/dualbus_region_router_chk.sv
module dualbus_region_router_chk #(
  parameter int ADDR_W = 24,
  parameter int IO_W   = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_busy,
  input logic              cpu_done,
  input logic              sys_stb,
  input logic              sys_io,
  input logic [ADDR_W-1:0] sys_addr,
  input logic              wb_cyc,
  input logic              wb_stb,
  input logic              wb_io,
  input logic              wb_ack,
  input logic [ADDR_W-1:0] wb_adr,
  input logic [DATA_W-1:0] wb_dat_o
);
  // R2/R4: never both buses at once
  p_one_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(sys_stb && wb_cyc));

  // R2: an accepted request starts exactly one bus access next cycle
  p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_busy) |=> (sys_stb || wb_cyc));

  // R3: IO flag on the system bus matches the address window
  p_sys_io_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sys_stb |-> (sys_io == (&sys_addr[ADDR_W-1:IO_W])));

  // R4: IO flag on Wishbone matches the address window
  p_wb_io_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cyc |-> (wb_io == (&wb_adr[ADDR_W-1:IO_W])));

  // R5: cycle and strobe held until acknowledged
  p_wb_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc && !wb_ack) |=> (wb_cyc && wb_stb));

  // R5: signals frozen while waiting
  p_wb_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc && !wb_ack) |=> ($stable(wb_adr) && $stable(wb_dat_o)));

  // R5: cycle ends right after the acknowledge
  p_wb_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc && wb_ack) |=> !wb_cyc);

  // R6: system strobe lasts one cycle
  p_sys_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sys_stb |=> !sys_stb);

  // R7: completion is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);
endmodule

bind dualbus_region_router dualbus_region_router_chk #(
  .ADDR_W (ADDR_W),
  .IO_W   (IO_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpu_req  (cpu_req),
  .cpu_busy (cpu_busy),
  .cpu_done (cpu_done),
  .sys_stb  (sys_stb),
  .sys_io   (sys_io),
  .sys_addr (sys_addr),
  .wb_cyc   (wb_cyc),
  .wb_stb   (wb_stb),
  .wb_io    (wb_io),
  .wb_ack   (wb_ack),
  .wb_adr   (wb_adr),
  .wb_dat_o (wb_dat_o)
);

// File: tb/dualbus_region_router_tb.sv
`timescale 1ns/1ps
module dualbus_region_router_tb;
  localparam int AW = 24;
  localparam int CW = 25;

  logic clk = 1'b0;
  logic rst_n;
  logic cpu_req, cpu_we;
  logic [CW-1:0] cpu_addr;
  logic [31:0] cpu_wdata;
  logic [3:0]  cpu_be;
  logic cpu_busy, cpu_done;
  logic [31:0] cpu_rdata;
  logic sys_stb, sys_io, sys_we;
  logic [AW-1:0] sys_addr;
  logic [31:0] sys_wdata;
  logic [3:0]  sys_be;
  logic sys_ack;
  logic [31:0] sys_rdata;
  logic wb_cyc, wb_stb, wb_we, wb_io;
  logic [AW-1:0] wb_adr;
  logic [31:0] wb_dat_o;
  logic [3:0]  wb_sel;
  logic wb_ack;
  logic [31:0] wb_dat_i;

  always #4 clk = ~clk;

  dualbus_region_router u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
    .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .sys_stb(sys_stb), .sys_io(sys_io), .sys_we(sys_we), .sys_addr(sys_addr),
    .sys_wdata(sys_wdata), .sys_be(sys_be), .sys_ack(sys_ack), .sys_rdata(sys_rdata),
    .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_io(wb_io),
    .wb_adr(wb_adr), .wb_dat_o(wb_dat_o), .wb_sel(wb_sel),
    .wb_ack(wb_ack), .wb_dat_i(wb_dat_i)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] sys_model(input logic [AW-1:0] a);
    return 32'hA5000000 ^ {8'h00, a};
  endfunction
  function automatic logic [31:0] wb_model(input logic [AW-1:0] a);
    return 32'h5A0000C3 ^ ({8'h00, a} * 3);
  endfunction
  function automatic bit exp_wb(input logic [CW-1:0] a);
    return a[AW];
  endfunction
  function automatic bit exp_io(input logic [CW-1:0] a);
    return &a[AW-1:16];
  endfunction

  // bus models and monitors, run 1 ns after each falling edge
  int sys_n, wb_n;
  int sys_dly, wb_dly;
  bit inj_sys, inj_wb;
  logic [AW-1:0] r_addr;
  logic r_io, r_we;
  logic [31:0] r_wdata;
  logic [3:0] r_be;

  initial begin
    bit sp = 0, wp = 0, prev_sys = 0, prev_wack = 0;
    int sc = 0, wc = 0;
    sys_ack = 0; wb_ack = 0; sys_rdata = 0; wb_dat_i = 0;
    forever begin
      @(negedge clk); #1;
      // R6: strobe never seen in two consecutive cycles
      if (prev_sys && sys_stb) chk(0, "R6 strobe longer than one cycle", 1, 0);
      // R5: cycle must be gone after an acknowledged cycle
      if (prev_wack && wb_cyc) chk(0, "R5 cycle not dropped after ack", 1, 0);
      prev_sys = sys_stb;
      prev_wack = wb_ack && wb_cyc;
      sys_ack = inj_sys; wb_ack = inj_wb;
      if (inj_sys) sys_rdata = 32'hDEAD0001;
      if (inj_wb)  wb_dat_i  = 32'hDEAD0002;
      if (sys_stb) begin
        sys_n++; sp = 1; sc = sys_dly;
        r_addr = sys_addr; r_io = sys_io; r_we = sys_we; r_wdata = sys_wdata; r_be = sys_be;
      end
      if (sp) begin
        if (sc == 0) begin sys_ack = 1; sys_rdata = sys_model(r_addr); sp = 0; end
        else sc--;
      end
      if (wb_cyc && !wp && !prev_wack) begin
        wb_n++; wp = 1; wc = wb_dly;
        r_addr = wb_adr; r_io = wb_io; r_we = wb_we; r_wdata = wb_dat_o; r_be = wb_sel;
        chk(wb_stb, "R5 stb with cyc", wb_stb, 1);
      end
      if (wp) begin
        if (wb_adr != r_addr || wb_dat_o != r_wdata || wb_sel != r_be || !wb_cyc)
          chk(0, "R5 held signals changed", wb_adr, r_addr);
        if (wc == 0) begin wb_ack = 1; wb_dat_i = wb_model(r_addr); wp = 0; end
        else wc--;
      end
    end
  end

  task automatic do_req(input logic [CW-1:0] a, input logic we, input logic [31:0] d,
                        input logic [3:0] be, input bit poke);
    int n;
    logic [31:0] exp_d, saved;
    string rq;
    @(negedge clk);
    sys_n = 0; wb_n = 0;
    cpu_req = 1; cpu_addr = a; cpu_we = we; cpu_wdata = d; cpu_be = be;
    @(negedge clk);
    cpu_req = 0;
    n = 0;
    while (!cpu_done && n < 40) begin
      if (poke && n == 0) begin cpu_req = 1; cpu_addr = ~a; cpu_wdata = ~d; end
      @(negedge clk);
      cpu_req = 0;
      n++;
    end
    chk(cpu_done, "R7 completion seen", cpu_done, 1);
    rq = exp_wb(a) ? "R4" : (exp_io(a) ? "R3" : "R2");
    chk(wb_n == (exp_wb(a) ? 1 : 0) && sys_n == (exp_wb(a) ? 0 : 1),
        {rq, " bus selection"}, {wb_n[31:0], sys_n[31:0]}, exp_wb(a) ? 64'h1_00000000 : 64'h1);
    chk(r_addr == a[AW-1:0], {rq, " address"}, r_addr, a[AW-1:0]);
    chk(r_io == exp_io(a), {rq, " io window flag"}, r_io, exp_io(a));
    chk(r_we == we && r_wdata == d && r_be == be, {rq, " we/data/be"}, {r_we, r_be, r_wdata}, {we, be, d});
    exp_d = exp_wb(a) ? wb_model(a[AW-1:0]) : sys_model(a[AW-1:0]);
    chk(cpu_rdata == exp_d, "R7 read data from serving bus", cpu_rdata, exp_d);
    saved = cpu_rdata;
    @(negedge clk);
    chk(!cpu_done, "R7 single completion pulse", cpu_done, 0);
    @(negedge clk);
    chk(cpu_rdata == saved, "R7 read data held", cpu_rdata, saved);
    if (poke) chk(sys_n + wb_n == 1, "R8 busy request ignored", sys_n + wb_n, 1);
  endtask

  initial begin
    #(8 * 150000);
    chk(0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'h1DB0_5EED));
    sys_dly = 0; wb_dly = 0; inj_sys = 0; inj_wb = 0;
    cpu_req = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0; cpu_be = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!sys_stb && !wb_cyc && !wb_stb && !cpu_done && cpu_rdata == 0, "R1 reset outputs",
        {sys_stb, wb_cyc, wb_stb, cpu_done}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!cpu_busy && !cpu_done && !sys_stb && !wb_cyc, "R1 idle after release",
        {cpu_busy, cpu_done, sys_stb, wb_cyc}, 0);

    // directed boundaries with mixed latencies
    sys_dly = 0; wb_dly = 0;
    do_req(25'h0000000, 0, 32'h0, 4'hF, 0);              // R2
    sys_dly = 2;
    do_req(25'h0FEFFFF, 1, 32'h11223344, 4'h1, 0);       // R2 last mem
    do_req(25'h0FF0000, 0, 32'h0, 4'hF, 0);              // R3 first io
    sys_dly = 3;
    do_req(25'h0FFFFFF, 1, 32'hCAFEF00D, 4'hC, 0);       // R3 top of system
    wb_dly = 0;
    do_req(25'h1000000, 0, 32'h0, 4'hF, 0);              // R4 first wishbone
    wb_dly = 3;
    do_req(25'h1FEFFFF, 1, 32'h01020304, 4'h3, 0);       // R4 last wb mem, R5 wait
    do_req(25'h1FF0000, 0, 32'h0, 4'hF, 0);              // R4 first wb io
    wb_dly = 1;
    do_req(25'h1FFFFFF, 1, 32'h99887766, 4'h8, 1);       // R4 top, R8 poke
    sys_dly = 2;
    do_req(25'h0000040, 0, 32'h0, 4'hF, 1);              // R8 poke on system

    // R9: stray acknowledges while idle
    held = cpu_rdata;
    @(negedge clk); inj_sys = 1; inj_wb = 1;
    @(negedge clk); inj_sys = 0; inj_wb = 0;
    @(negedge clk);
    chk(!cpu_done, "R9 stray ack gives no completion", cpu_done, 0);
    chk(cpu_rdata == held, "R9 stray ack leaves read data", cpu_rdata, held);

    // random spread over the four classes
    for (int i = 0; i < 160; i++) begin
      logic [CW-1:0] a;
      int cls;
      cls = $urandom % 4;
      a[AW-1:0] = (cls % 2 == 1) ? {8'hFF, 16'($urandom)} : 24'($urandom % 32'hFF0000);
      a[AW] = (cls >= 2);
      sys_dly = $urandom % 4;
      wb_dly = $urandom % 4;
      do_req(a, 1'($urandom), $urandom, 4'($urandom), (i % 7) == 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule